// File: doc/BRIEF.md
# Configurable GPIO Port with Edge and Level Interrupts

This block is a parameterised general-purpose I/O port (eight pins by default) with a small register bus. Each pin picks its own mode from three control bits: a direction bit and two function-select bits. The possible modes are push-pull output, plain input, level-sensitive interrupt and single-edge interrupt. The data register has two uses. In output mode it holds the value driven onto the pin. In interrupt modes it selects the active level or edge. A read of the data register always returns the synchronised pin values and never the stored contents.

Edge interrupts are latched in per-pin pending flags. Software clears a flag by writing 1 to its bit of the clear register, and the same address reads the pending flags back. Level interrupts are not latched: they follow the pin. The single interrupt output is the OR of every pending flag and every active level condition.

Register map (3-bit address): 0 data, 1 direction, 2 select-low, 3 select-high, 4 pending flags (read) and write-1-to-clear (write). Other addresses read as zero and ignore writes.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones, both select registers and the data register read zero, no pin is driven (pin_oe_o = 0), no flag is pending and irq_o is low.
- R2: A pin whose direction bit is 0, and whose two select bits are not both 1, is in output mode: pin_oe_o is 1 for it and pin_out_o carries its data register bit.
- R3: A read at address 0 returns the pin inputs after a synchroniser of SYNC_STAGES flops. A pin change becomes visible after exactly SYNC_STAGES rising clock edges. The stored data value is never returned.
- R4: A pin whose direction bit is 1, and whose two select bits are not both 1, is a plain input: it is not driven, and edges on it set no flag and raise no interrupt.
- R5: With direction, select-low and select-high all 1 and data bit 1, a rising edge sets the pin's pending flag. The flag and irq_o appear SYNC_STAGES+1 edges after the pin changes. A falling edge sets nothing.
- R6: In the same edge mode with data bit 0, a falling edge sets the flag and a rising edge sets nothing.
- R7: A pending flag stays set after the pin returns. Writing 1 to its bit at address 4 clears it. Writing 0 to that bit leaves it set. Address 4 reads back the flags.
- R8: With select-low and select-high 1 and direction 0, the pin is a level interrupt. It is not driven. irq_o is high while the synchronised pin equals the data bit and low otherwise. No flag is latched.
- R9: When a qualifying edge and a write-1 clear of the same bit arrive in the same cycle, the flag stays set.
- R10: irq_o is the OR over all pins. Clearing one pin's flag leaves irq_o high while another flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data for bus_addr_i (combinational) |
| pin_i | input | WIDTH | Pad input values |
| pin_oe_o | output | WIDTH | Per-pin output enable |
| pin_out_o | output | WIDTH | Per-pin output value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with the default eight pins and two synchroniser stages. With eight pins, each interrupt mode can sit on its own pin next to plain inputs, so the OR and the per-bit clears are checked across pins that share the port. With two stages, the sampling and edge-latch latencies are short enough to check at one exact cycle each. That makes the same-cycle collision between an edge and a clear reachable with a directed write.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_OUT   = 2'd0,
      PM_IN    = 2'd1,
      PM_LEVEL = 2'd2,
      PM_EDGE  = 2'd3
   } pin_mode_e;

   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIR    = 3'd1;
   localparam logic [ADDR_W-1:0] A_SEL_LO = 3'd2;
   localparam logic [ADDR_W-1:0] A_SEL_HI = 3'd3;
   localparam logic [ADDR_W-1:0] A_CLR    = 3'd4;

   // Both select bits set -> interrupt mode; direction picks edge or level.
   function automatic pin_mode_e decode_mode(input logic dir,
                                             input logic sel_lo,
                                             input logic sel_hi);
      if (sel_lo && sel_hi) return dir ? PM_EDGE : PM_LEVEL;
      return dir ? PM_IN : PM_OUT;
   endfunction

endpackage

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] q_prev_o
);

   logic [WIDTH-1:0] chain_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   // One more flop holds last cycle's sample for edge comparison.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= chain_q[STAGES-1];
   end

   assign q_o      = chain_q[STAGES-1];
   assign q_prev_o = prev_q;

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WIDTH-1:0]  wdata_i,
   input  logic [WIDTH-1:0]  smp_i,
   input  logic [WIDTH-1:0]  pend_i,
   output logic [WIDTH-1:0]  dir_o,
   output logic [WIDTH-1:0]  sel_lo_o,
   output logic [WIDTH-1:0]  sel_hi_o,
   output logic [WIDTH-1:0]  dat_o,
   output logic [WIDTH-1:0]  clr_o,
   output logic [WIDTH-1:0]  rdata_o
);

   logic [WIDTH-1:0] dir_q, sel_lo_q, sel_hi_q, dat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dir_q    <= '1;
         sel_lo_q <= '0;
         sel_hi_q <= '0;
         dat_q    <= '0;
      end else if (wr_i) begin
         case (addr_i)
            A_DATA:   dat_q    <= wdata_i;
            A_DIR:    dir_q    <= wdata_i;
            A_SEL_LO: sel_lo_q <= wdata_i;
            A_SEL_HI: sel_hi_q <= wdata_i;
            default:  ;
         endcase
      end
   end

   // Clear pulse lasts only for the write cycle.
   assign clr_o = (wr_i && addr_i == A_CLR) ? wdata_i : '0;

   always_comb begin
      case (addr_i)
         A_DATA:   rdata_o = smp_i;
         A_DIR:    rdata_o = dir_q;
         A_SEL_LO: rdata_o = sel_lo_q;
         A_SEL_HI: rdata_o = sel_hi_q;
         A_CLR:    rdata_o = pend_i;
         default:  rdata_o = '0;
      endcase
   end

   assign dir_o    = dir_q;
   assign sel_lo_o = sel_lo_q;
   assign sel_hi_o = sel_hi_q;
   assign dat_o    = dat_q;

endmodule

// File: rtl/gpio_port_pin.sv
`timescale 1ns/1ps
module gpio_port_pin
   import gpio_port_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic dir_i,
   input  logic sel_lo_i,
   input  logic sel_hi_i,
   input  logic dat_i,
   input  logic smp_i,
   input  logic smp_prev_i,
   input  logic clr_i,
   output logic oe_o,
   output logic out_o,
   output logic pend_o,
   output logic lvl_o
);

   pin_mode_e mode;
   logic      rise, fall, hit, pend_q;

   assign mode = decode_mode(dir_i, sel_lo_i, sel_hi_i);
   assign rise = smp_i & ~smp_prev_i;
   assign fall = ~smp_i & smp_prev_i;
   assign hit  = (mode == PM_EDGE) && (dat_i ? rise : fall);

   // A new edge takes priority over a clear in the same cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q <= 1'b0;
      else if (hit)   pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
   end

   assign oe_o   = (mode == PM_OUT);
   assign out_o  = dat_i & oe_o;
   assign lvl_o  = (mode == PM_LEVEL) && (smp_i == dat_i);
   assign pend_o = pend_q;

   a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> pend_q);

   a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !hit) |=> !pend_q);

   a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !clr_i) |=> pend_q);

   a_r4_no_set_outside_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q && mode != PM_EDGE) |=> !pend_q);

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [2:0]        bus_addr_i,
   input  logic [WIDTH-1:0]  bus_wdata_i,
   output logic [WIDTH-1:0]  bus_rdata_o,
   input  logic [WIDTH-1:0]  pin_i,
   output logic [WIDTH-1:0]  pin_oe_o,
   output logic [WIDTH-1:0]  pin_out_o,
   output logic              irq_o
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port: WIDTH must be 1..32");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be 2..4");
   end

   logic [WIDTH-1:0] smp, smp_prev;
   logic [WIDTH-1:0] dir, sel_lo, sel_hi, dat, clr;
   logic [WIDTH-1:0] pend, lvl;

   gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (pin_i),
      .q_o      (smp),
      .q_prev_o (smp_prev)
   );

   gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .smp_i    (smp),
      .pend_i   (pend),
      .dir_o    (dir),
      .sel_lo_o (sel_lo),
      .sel_hi_o (sel_hi),
      .dat_o    (dat),
      .clr_o    (clr),
      .rdata_o  (bus_rdata_o)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      gpio_port_pin u_pin (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .dir_i      (dir[i]),
         .sel_lo_i   (sel_lo[i]),
         .sel_hi_i   (sel_hi[i]),
         .dat_i      (dat[i]),
         .smp_i      (smp[i]),
         .smp_prev_i (smp_prev[i]),
         .clr_i      (clr[i]),
         .oe_o       (pin_oe_o[i]),
         .out_o      (pin_out_o[i]),
         .pend_o     (pend[i]),
         .lvl_o      (lvl[i])
      );
   end

   assign irq_o = (|pend) | (|lvl);

   a_r1_reset_inputs: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (pin_oe_o == '0 && !irq_o));

   a_r10_irq_any_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pend) |-> irq_o);

endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr = 1'b0;
   logic [2:0]   addr = 3'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [W-1:0] pins = '0;
   logic [W-1:0] oe, out;
   logic         irq;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] dat_sh = '0, dir_sh = '1, slo_sh = '0, shi_sh = '0;

   always #5 clk = ~clk;

   gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) u_gpio_port (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
      .pin_oe_o(oe), .pin_out_o(out), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
      addr = a; #1; v = rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_cfg();
      bus_wr(3'd0, dat_sh); bus_wr(3'd2, slo_sh);
      bus_wr(3'd3, shi_sh); bus_wr(3'd1, dir_sh);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      chk("R1 oe", oe, 0); chk("R1 irq", irq, 0);
      rd(3'd1, v); chk("R1 dir", v, 8'hFF);
      rd(3'd2, v); chk("R1 sel_lo", v, 0);
      rd(3'd3, v); chk("R1 sel_hi", v, 0);
      rd(3'd4, v); chk("R1 pending", v, 0);
   endtask

   task automatic t_output();
      logic [W-1:0] v;
      bus_wr(3'd1, 8'h00); bus_wr(3'd0, 8'hA5);
      chk("R2 oe all out", oe, 8'hFF); chk("R2 out value", out, 8'hA5);
      pins = 8'h3C;
      edges(1); rd(3'd0, v); chk("R3 one edge still old", v, 8'h00);
      edges(1); rd(3'd0, v); chk("R3 pins after two edges", v, 8'h3C);
      bus_wr(3'd1, 8'hFF); bus_wr(3'd0, 8'h00);
      chk("R4 inputs not driven", oe, 0);
      pins = 8'h00; edges(3);
   endtask

   task automatic t_input();
      logic [W-1:0] v;
      pins = 8'hFF; edges(4); chk("R4 no irq on rise", irq, 0);
      pins = 8'h00; edges(4); chk("R4 no irq on fall", irq, 0);
      rd(3'd4, v); chk("R4 no pending", v, 0);
   endtask

   task automatic t_edge_rise();
      logic [W-1:0] v;
      dat_sh[0] = 1; slo_sh[0] = 1; shi_sh[0] = 1; wr_cfg(); edges(2);
      pins[0] = 1;
      edges(2); chk("R5 not yet latched", irq, 0);
      edges(1); chk("R5 irq on rise", irq, 1);
      rd(3'd4, v); chk("R5 pending bit0", v, 8'h01);
      pins[0] = 0; edges(4); chk("R7 latched after pin returns", irq, 1);
      bus_wr(3'd4, 8'hFE); rd(3'd4, v); chk("R7 write 0 no effect", v, 8'h01);
      bus_wr(3'd4, 8'h01); rd(3'd4, v); chk("R7 write 1 clears", v, 8'h00);
      chk("R7 irq low after clear", irq, 0);
      pins[0] = 1; edges(4); bus_wr(3'd4, 8'h01);
      pins[0] = 0; edges(4);
      rd(3'd4, v); chk("R5 falling ignored", v, 0);
   endtask

   task automatic t_edge_fall();
      logic [W-1:0] v;
      pins[1] = 1; edges(4);
      dat_sh[1] = 0; slo_sh[1] = 1; shi_sh[1] = 1; wr_cfg(); edges(2);
      pins[1] = 0; edges(3);
      rd(3'd4, v); chk("R6 pending on fall", v, 8'h02);
      chk("R6 irq on fall", irq, 1);
      bus_wr(3'd4, 8'h02);
      pins[1] = 1; edges(4);
      rd(3'd4, v); chk("R6 rising ignored", v, 0);
   endtask

   task automatic t_level();
      logic [W-1:0] v;
      dat_sh[2] = 1; slo_sh[2] = 1; shi_sh[2] = 1; dir_sh[2] = 0; wr_cfg();
      chk("R8 level pin not driven", oe[2], 0);
      pins[2] = 0; edges(2); chk("R8 idle level", irq, 0);
      pins[2] = 1; edges(2); chk("R8 active level", irq, 1);
      rd(3'd4, v); chk("R8 not latched", v, 0);
      pins[2] = 0; edges(2); chk("R8 follows pin", irq, 0);
   endtask

   task automatic t_same_cycle();
      logic [W-1:0] v;
      pins[0] = 1; edges(4);
      rd(3'd4, v); chk("R9 setup pending", v, 8'h01);
      pins[0] = 0; edges(4);
      pins[0] = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_wr(3'd4, 8'h01);
      rd(3'd4, v); chk("R9 edge wins over clear", v, 8'h01);
      bus_wr(3'd4, 8'h01);
      rd(3'd4, v); chk("R9 plain clear afterwards", v, 0);
      pins[0] = 0; edges(4);
   endtask

   task automatic t_or();
      logic [W-1:0] v;
      pins[0] = 1; pins[1] = 0; edges(4);
      rd(3'd4, v); chk("R10 both pending", v, 8'h03);
      bus_wr(3'd4, 8'h01);
      chk("R10 irq kept by other pin", irq, 1);
      rd(3'd4, v); chk("R10 other flag left", v, 8'h02);
      bus_wr(3'd4, 8'h02);
      chk("R10 irq low when none", irq, 0);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_output();
      t_input();
      t_edge_rise();
      t_edge_fall();
      t_level();
      t_same_cycle();
      t_or();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule